// File: doc/BRIEF.md
# Markov-Source Weighted Scan Bit Generator

This block feeds a scan chain with a biased pseudo-random serial stream for built-in self-test. The stream is not a set of independent weighted bits. It comes from a two-state machine whose single state bit is the output value. On every generated bit the machine decides whether to flip that state bit, using a weighted random bit. The weight of that bit depends on the current state: one probability sets the chance of leaving state 0, and a second sets the chance of leaving state 1. The chance of staying in a state is implied, so only these two leave-probabilities are configured.

The chain is split into fixed-length virtual subchains, and each subchain has its own pair of leave-probability codes. A per-position inversion mask can flip the generated value at any chain position before it is shifted in. This moves the value at that position toward the weight it needs. Both the code table and the mask are written through a small configuration port, and writes are taken only while generation is stopped. Whenever `gen_en` is high, one bit is produced per clock, and `scan_valid` marks it one cycle later.

Top module: `markov_scan_gen`

## Requirements
- R1: A synchronous active-high reset clears the state bit to 0, loads the LFSR with 16'hACE1, sets the chain position to 0, clears every probability code to 0 and every mask bit to 0, and drives `scan_valid` and `scan_bit` low.
- R2: A 16-bit LFSR steps on every clock after reset, whether generation is enabled or not. Each step shifts left and puts bit15^bit13^bit12^bit10 into bit 0. The LFSR never holds zero.
- R3: A probability code turns three random bits r[2:0] into one weighted bit. Code 0 gives r0&r1&r2 (1/8). Code 1 gives r0&r1 (1/4). Code 2 gives r0 (1/2). Code 3 gives r0|r1 (3/4). Code 4 gives r0|r1|r2 (7/8).
- R4: In state 0 the flip decision uses the subchain's leave-0 code on LFSR bits [2:0]. In state 1 it uses the leave-1 code on LFSR bits [5:3]. The new state is the old state XOR the decision.
- R5: One cycle after a clock edge with `gen_en` high, `scan_valid` is 1 and `scan_bit` is the new state XOR the mask bit of the current position. After an edge with `gen_en` low, both outputs are 0 and the state bit holds.
- R6: The position advances by one per generated bit and wraps to 0 after SUB_LEN*NUM_SUB bits. The codes used are those of subchain position/SUB_LEN.
- R7: Writes to the code table or to the mask take effect only on edges where `gen_en` is low. Writes on other edges are ignored. Writes to a subchain index of NUM_SUB or above, or to a position of SUB_LEN*NUM_SUB or above, are also ignored.
- R8: Mask bit k set to 1 inverts the output at chain position k only. The state sequence is unaffected.
- R9: Codes 5, 6 and 7 behave as code 2 (probability 1/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Produce one bit on this edge |
| cfg_prob_we | input | 1 | Write a code pair into the table |
| cfg_sub | input | SUB_W | Subchain index for a code write |
| cfg_p01 | input | 3 | Leave-state-0 probability code |
| cfg_p10 | input | 3 | Leave-state-1 probability code |
| cfg_inv_we | input | 1 | Write one inversion mask bit |
| cfg_inv_pos | input | POS_W | Chain position of the mask bit |
| cfg_inv_val | input | 1 | Mask bit value |
| scan_bit | output | 1 | Serial scan-in bit |
| scan_valid | output | 1 | Marks a generated bit |

## Verification
The bench builds the block with SUB_LEN=4 and NUM_SUB=3, a twelve-bit chain. With that size the position wraps and each subchain boundary is crossed many times in a few dozen cycles. A short run therefore exercises every table entry, every mask position and the wrap back to subchain 0. Idle gaps inserted while generation runs show that the LFSR keeps stepping and that the state bit holds while stopped. Runs at the extreme codes and at the 5 to 7 codes show each weighting function.

// File: rtl/mkv_pkg.sv
package mkv_pkg;

    localparam int unsigned RND_W = 16;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
    localparam int unsigned CODE_W = 3;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t leave0;
        code_t leave1;
    } prob_pair_t;

    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] cur);
        return {cur[RND_W-2:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
    endfunction

    function automatic logic shape_bit(input code_t code, input logic [2:0] r);
        logic w;
        case (code)
            3'd0:    w = r[0] & r[1] & r[2];
            3'd1:    w = r[0] & r[1];
            3'd3:    w = r[0] | r[1];
            3'd4:    w = r[0] | r[1] | r[2];
            default: w = r[0];
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mkv_lfsr.sv
module mkv_lfsr
    import mkv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [RND_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= RND_SEED;
        else     q <= rnd_step(q);
    end

    AST_RND_NONZERO: assert property (@(posedge clk) disable iff (rst) q != '0); // R2
    AST_RND_SHIFTS:  assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> q[RND_W-1:1] == $past(q[RND_W-2:0])); // R2

endmodule

// File: rtl/mkv_pos_ctr.sv
module mkv_pos_ctr #(
    parameter int unsigned SUB_LEN = 48,
    parameter int unsigned NUM_SUB = 4,
    localparam int unsigned CHAIN  = SUB_LEN * NUM_SUB,
    localparam int unsigned POS_W  = $clog2(CHAIN),
    localparam int unsigned SUB_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
    localparam int unsigned OFF_W  = (SUB_LEN > 1) ? $clog2(SUB_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [POS_W-1:0] pos,
    output logic [SUB_W-1:0] sub
);

    logic [OFF_W-1:0] off;
    logic             off_last;
    logic             pos_last;

    assign off_last = (int'(off) == SUB_LEN - 1);
    assign pos_last = (int'(pos) == CHAIN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            sub <= '0;
            off <= '0;
        end else if (adv) begin
            if (pos_last) begin
                pos <= '0;
                sub <= '0;
                off <= '0;
            end else begin
                pos <= pos + 1'b1;
                if (off_last) begin
                    off <= '0;
                    sub <= sub + 1'b1;
                end else begin
                    off <= off + 1'b1;
                end
            end
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst) int'(pos) < CHAIN); // R6
    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst) int'(sub) < NUM_SUB); // R6
    AST_POS_WRAP:  assert property (@(posedge clk) disable iff (rst)
        adv && pos_last |=> pos == '0 && sub == '0); // R6
    AST_POS_HOLD:  assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos)); // R6

endmodule

// File: rtl/mkv_cfg_regs.sv
module mkv_cfg_regs
    import mkv_pkg::*;
#(
    parameter int unsigned SUB_LEN = 48,
    parameter int unsigned NUM_SUB = 4,
    localparam int unsigned CHAIN  = SUB_LEN * NUM_SUB,
    localparam int unsigned POS_W  = $clog2(CHAIN),
    localparam int unsigned SUB_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             prob_we,
    input  logic [SUB_W-1:0] wr_sub,
    input  code_t            wr_p01,
    input  code_t            wr_p10,
    input  logic             inv_we,
    input  logic [POS_W-1:0] wr_pos,
    input  logic             wr_inv,
    input  logic [SUB_W-1:0] rd_sub,
    input  logic [POS_W-1:0] rd_pos,
    output prob_pair_t       rd_pair,
    output logic             rd_inv
);

    prob_pair_t [NUM_SUB-1:0] tbl;
    logic       [CHAIN-1:0]   mask;

    for (genvar g = 0; g < NUM_SUB; g++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[g] <= '0;
            end else if (!busy && prob_we && int'(wr_sub) == g) begin
                tbl[g].leave0 <= wr_p01;
                tbl[g].leave1 <= wr_p10;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (!busy && inv_we && int'(wr_pos) < CHAIN) begin
            mask[wr_pos] <= wr_inv;
        end
    end

    assign rd_pair = tbl[rd_sub];
    assign rd_inv  = mask[rd_pos];

    AST_TBL_FROZEN:  assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(tbl)); // R7
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mask)); // R7

endmodule

// File: rtl/markov_scan_gen.sv
module markov_scan_gen
    import mkv_pkg::*;
#(
    parameter int unsigned SUB_LEN = 48,
    parameter int unsigned NUM_SUB = 4,
    localparam int unsigned CHAIN  = SUB_LEN * NUM_SUB,
    localparam int unsigned POS_W  = $clog2(CHAIN),
    localparam int unsigned SUB_W  = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en,
    input  logic             cfg_prob_we,
    input  logic [SUB_W-1:0] cfg_sub,
    input  logic [2:0]       cfg_p01,
    input  logic [2:0]       cfg_p10,
    input  logic             cfg_inv_we,
    input  logic [POS_W-1:0] cfg_inv_pos,
    input  logic             cfg_inv_val,
    output logic             scan_bit,
    output logic             scan_valid
);

    logic [RND_W-1:0] rnd;
    logic [POS_W-1:0] pos;
    logic [SUB_W-1:0] sub;
    prob_pair_t       pair;
    logic             inv_here;
    logic             state_q;
    logic             flip;
    logic             state_d;

    mkv_lfsr u_rnd (
        .clk (clk),
        .rst (rst),
        .q   (rnd)
    );

    mkv_pos_ctr #(.SUB_LEN(SUB_LEN), .NUM_SUB(NUM_SUB)) u_pos (
        .clk (clk),
        .rst (rst),
        .adv (gen_en),
        .pos (pos),
        .sub (sub)
    );

    mkv_cfg_regs #(.SUB_LEN(SUB_LEN), .NUM_SUB(NUM_SUB)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .busy    (gen_en),
        .prob_we (cfg_prob_we),
        .wr_sub  (cfg_sub),
        .wr_p01  (cfg_p01),
        .wr_p10  (cfg_p10),
        .inv_we  (cfg_inv_we),
        .wr_pos  (cfg_inv_pos),
        .wr_inv  (cfg_inv_val),
        .rd_sub  (sub),
        .rd_pos  (pos),
        .rd_pair (pair),
        .rd_inv  (inv_here)
    );

    // State-selected weighted bit drives the toggle input.
    always_comb begin
        if (state_q) flip = shape_bit(pair.leave1, rnd[5:3]);
        else         flip = shape_bit(pair.leave0, rnd[2:0]);
        state_d = state_q ^ flip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= 1'b0;
            scan_bit   <= 1'b0;
            scan_valid <= 1'b0;
        end else if (gen_en) begin
            state_q    <= state_d;
            scan_bit   <= state_d ^ inv_here;
            scan_valid <= 1'b1;
        end else begin
            scan_bit   <= 1'b0;
            scan_valid <= 1'b0;
        end
    end

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> $stable(state_q)); // R5
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        gen_en |=> scan_valid); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> !scan_valid && !scan_bit); // R5
    AST_STATE_PATH: assert property (@(posedge clk) disable iff (rst)
        gen_en && !$past(rst) |=> scan_bit == (state_q ^ $past(inv_here))); // R8

endmodule

// File: tb/markov_scan_gen_test.sv
`timescale 1ns/1ps
module markov_scan_gen_test;

    localparam int SUB = 4;
    localparam int NS  = 3;
    localparam int CH  = SUB * NS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gen_en = 1'b0;
    logic       cfg_prob_we = 1'b0;
    logic [1:0] cfg_sub = '0;
    logic [2:0] cfg_p01 = '0;
    logic [2:0] cfg_p10 = '0;
    logic       cfg_inv_we = 1'b0;
    logic [3:0] cfg_inv_pos = '0;
    logic       cfg_inv_val = 1'b0;
    logic       scan_bit;
    logic       scan_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference state.
    logic [15:0] m_rnd;
    int          m_state, m_pos;
    int          m_c0[NS];
    int          m_c1[NS];
    int          m_inv[CH];
    int          e_bit, e_valid;

    always #5 clk = ~clk;

    markov_scan_gen #(.SUB_LEN(SUB), .NUM_SUB(NS)) uut (
        .clk(clk), .rst(rst), .gen_en(gen_en),
        .cfg_prob_we(cfg_prob_we), .cfg_sub(cfg_sub),
        .cfg_p01(cfg_p01), .cfg_p10(cfg_p10),
        .cfg_inv_we(cfg_inv_we), .cfg_inv_pos(cfg_inv_pos),
        .cfg_inv_val(cfg_inv_val),
        .scan_bit(scan_bit), .scan_valid(scan_valid)
    );

    function automatic int weigh(int code, int a, int b, int c);
        if (code == 0) return a & b & c;
        if (code == 1) return a & b;
        if (code == 3) return a | b;
        if (code == 4) return a | b | c;
        return a;
    endfunction

    function automatic void model(input int r, en, pwe, sb, a, b, iwe, ip, iv);
        int t;
        if (r != 0) begin
            m_rnd = 16'hACE1; m_state = 0; m_pos = 0; e_bit = 0; e_valid = 0;
            for (int i = 0; i < NS; i++) begin m_c0[i] = 0; m_c1[i] = 0; end
            for (int i = 0; i < CH; i++) m_inv[i] = 0;
            return;
        end
        if (en != 0) begin
            if (m_state == 0) t = weigh(m_c0[m_pos / SUB], m_rnd[0], m_rnd[1], m_rnd[2]);
            else              t = weigh(m_c1[m_pos / SUB], m_rnd[3], m_rnd[4], m_rnd[5]);
            m_state = m_state ^ t;
            e_bit   = m_state ^ m_inv[m_pos];
            e_valid = 1;
            m_pos   = (m_pos + 1) % CH;
        end else begin
            e_bit = 0; e_valid = 0;
            if (pwe != 0 && sb < NS) begin m_c0[sb] = a; m_c1[sb] = b; end
            if (iwe != 0 && ip < CH) m_inv[ip] = iv;
        end
        m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
    endfunction

    task automatic cyc(input int r, en, pwe, sb, a, b, iwe, ip, iv, input string tag);
        @(negedge clk);
        rst = (r != 0); gen_en = (en != 0);
        cfg_prob_we = (pwe != 0); cfg_sub = 2'(sb); cfg_p01 = 3'(a); cfg_p10 = 3'(b);
        cfg_inv_we = (iwe != 0); cfg_inv_pos = 4'(ip); cfg_inv_val = (iv != 0);
        model(r, en, pwe, sb, a, b, iwe, ip, iv);
        @(posedge clk);
        #1;
        checks++;
        if (scan_valid !== 1'(e_valid) || scan_bit !== 1'(e_bit)) begin
            fails++;
            $display("FAIL %s: valid/bit got %0b/%0b expected %0d/%0d", tag,
                     scan_valid, scan_bit, e_valid, e_bit);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic set_pair(input int sb, a, b, input string tag);
        cyc(0, 0, 1, sb, a, b, 0, 0, 0, tag);
    endtask

    task automatic set_inv(input int p, v, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, p, v, tag);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        run(12, "R1");                       // all codes 0 after reset
        set_pair(0, 0, 4, "R3"); set_pair(1, 1, 3, "R3"); set_pair(2, 2, 2, "R3");
        set_pair(3, 4, 4, "R7");             // out-of-range subchain
        set_inv(1, 1, "R8"); set_inv(5, 1, "R8"); set_inv(10, 1, "R8");
        set_inv(13, 1, "R7");                // out-of-range position
        run(40, "R4");
        idle(5, "R5");
        run(30, "R6");
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, i % NS, 4, 0, 1, i, 1, "R7");
        run(30, "R7");
        for (int i = 0; i < 40; i++) cyc(0, i % 3 != 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        set_pair(0, 5, 6, "R9"); set_pair(1, 7, 5, "R9"); set_pair(2, 6, 7, "R9");
        run(30, "R9");
        set_pair(0, 1, 3, "R3"); set_pair(1, 0, 4, "R3"); set_pair(2, 4, 0, "R3");
        set_inv(1, 0, "R8"); set_inv(5, 0, "R8"); set_inv(10, 0, "R8");
        run(36, "R3");
        for (int i = 0; i < CH; i++) set_inv(i, i % 2, "R8");
        run(36, "R8");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, "R1");
        run(12, "R1");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule